// File: doc/BRIEF.md
# Quadrature to Count-Clock Converter

This block turns the two phase-shifted signals of an incremental encoder into count pulses for an external up/down counter. It runs on one system clock. Each encoder input first passes a two-flop synchronizer. It then passes a filter that accepts a new level only after the input has held that level for `FILT_LEN` consecutive clocks. A decoder compares the previous and current filtered pairs and reports a count event together with its direction.

A mode input selects the resolution. In x4 mode every legal edge on either input counts. In x1 mode only one edge per full four-edge cycle counts: the edge that returns the pair to A=0, B=0. Two output formats are driven at the same time, and both are active low. The first is a separate up pulse train and down pulse train. The second is a combined count clock with a direction level. The direction level is set when a pulse starts and holds until the pulse ends, so a counter that counts on the rising edge of the clock always sees a settled direction.

The width of the low pulse comes from a configuration input and is given in clocks. If both inputs change in one decoded step, the step is illegal. It produces no pulse and sets a sticky error flag.

Top module: `quad_clk_conv`

## Requirements
- R1: After reset, `up_n`, `dn_n` and `cnt_clk_n` are high and `dir` and `err` are low.
- R2: With `mode_x4`=1, every filtered step in which exactly one of A or B changes produces exactly one output pulse.
- R3: With `mode_x4`=0, a pulse is produced only on a step into {A,B}=00. A step from 01 counts up and a step from 10 counts down. All other steps produce no pulse.
- R4: The forward order of {A,B} is 00→10→11→01→00 (A leads B). Forward steps pulse `up_n` and reverse steps pulse `dn_n`.
- R5: `cnt_clk_n` goes low for every pulse on either `up_n` or `dn_n`, and it is low only then. `up_n` and `dn_n` are never low together.
- R6: `dir` is 1 during an up pulse and 0 during a down pulse. It does not change while `cnt_clk_n` is low.
- R7: An uninterrupted pulse is low for `pw_cfg` clocks. A value of 0 is treated as 1.
- R8: A change on A or B that lasts fewer than `FILT_LEN` clocks produces no pulse.
- R9: A step where A and B change together produces no pulse and sets `err`. `err` stays set until reset.
- R10: An event that arrives while a pulse is low ends that pulse. The output then stays high for one clock and starts a new full-width pulse, so the number of pulses equals the number of events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_a | input | 1 | Raw encoder phase A |
| enc_b | input | 1 | Raw encoder phase B |
| mode_x4 | input | 1 | 1 = count every edge, 0 = count once per cycle |
| pw_cfg | input | PW_W | Low pulse width in clocks (0 acts as 1) |
| up_n | output | 1 | Active-low up count pulse |
| dn_n | output | 1 | Active-low down count pulse |
| cnt_clk_n | output | 1 | Active-low combined count clock |
| dir | output | 1 | Direction: 1 up, 0 down |
| err | output | 1 | Sticky illegal double-change flag |

## Verification
Random walks that reverse direction at random steps test whether the decoder tracks both directions in both modes. A design that confused the forward order would swap its up and down counts. In x1 mode a design that fired on the wrong phase would count at the wrong points of a cycle and produce the wrong totals. A glitch shorter than the filter length tests R8, and a design with a weak filter would emit stray pulses. A simultaneous change of both inputs tests R9: a design that counted it would add a pulse, and one that cleared the flag would lose the error. A run with pulses wider than the edge spacing tests R10, where a design that merged events would come up short in its counts. A width setting of zero tests that the pulse never disappears.

// File: rtl/qcc_pkg.sv
package qcc_pkg;
  typedef logic [1:0] ab_t;   // {A,B}

  // Forward order (A leads B): 00 -> 10 -> 11 -> 01 -> 00
  function automatic ab_t fwd_next(ab_t s);
    case (s)
      2'b00:   return 2'b10;
      2'b10:   return 2'b11;
      2'b11:   return 2'b01;
      default: return 2'b00;
    endcase
  endfunction
endpackage

// File: rtl/qcc_filter.sv
module qcc_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic level
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      run_q  <= '0;
      level  <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], raw};
      if (sync_q[1] == level) begin
        run_q <= '0;
      end else if (run_q == CW'(FILT_LEN - 1)) begin
        run_q <= '0;
        level <= sync_q[1];
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/qcc_decode.sv
module qcc_decode
  import qcc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  ab_t  ab,
  input  logic mode_x4,
  output logic ev,
  output logic ev_up,
  output logic err
);
  ab_t  prev_q;
  logic step_f, step_r, dbl;

  always_comb begin
    step_f = (ab != prev_q) && (ab == fwd_next(prev_q));
    step_r = (ab != prev_q) && (prev_q == fwd_next(ab));
    dbl    = (ab ^ prev_q) == 2'b11;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 2'b00;
      ev     <= 1'b0;
      ev_up  <= 1'b0;
      err    <= 1'b0;
    end else begin
      prev_q <= ab;
      ev     <= 1'b0;
      if (dbl) err <= 1'b1;
      if (step_f || step_r) begin
        if (mode_x4 || ab == 2'b00) begin
          ev    <= 1'b1;
          ev_up <= step_f;
        end
      end
    end
  end
endmodule

// File: rtl/qcc_pulse.sv
module qcc_pulse #(
  parameter int PW_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ev,
  input  logic            ev_up,
  input  logic [PW_W-1:0] pw_cfg,
  output logic            up_n,
  output logic            dn_n,
  output logic            cnt_clk_n,
  output logic            dir
);
  logic            low_q, low_nx;
  logic            dir_nx;
  logic            pend_q, pend_nx;
  logic            pdir_q, pdir_nx;
  logic [PW_W-1:0] cnt_q, cnt_nx;
  logic [PW_W-1:0] pw_eff;

  always_comb begin
    pw_eff  = (pw_cfg == '0) ? PW_W'(1) : pw_cfg;
    low_nx  = low_q;
    dir_nx  = dir;
    pend_nx = pend_q;
    pdir_nx = pdir_q;
    cnt_nx  = cnt_q;
    if (ev) begin
      if (low_q) begin          // cut short, one-clock high gap
        low_nx  = 1'b0;
        pend_nx = 1'b1;
        pdir_nx = ev_up;
      end else if (pend_q) begin
        pdir_nx = ev_up;
      end else begin
        low_nx = 1'b1;
        dir_nx = ev_up;
        cnt_nx = pw_eff - 1'b1;
      end
    end else if (pend_q) begin
      low_nx  = 1'b1;
      dir_nx  = pdir_q;
      cnt_nx  = pw_eff - 1'b1;
      pend_nx = 1'b0;
    end else if (low_q) begin
      if (cnt_q == '0) low_nx = 1'b0;
      else             cnt_nx = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      low_q     <= 1'b0;
      dir       <= 1'b0;
      pend_q    <= 1'b0;
      pdir_q    <= 1'b0;
      cnt_q     <= '0;
      up_n      <= 1'b1;
      dn_n      <= 1'b1;
      cnt_clk_n <= 1'b1;
    end else begin
      low_q     <= low_nx;
      dir       <= dir_nx;
      pend_q    <= pend_nx;
      pdir_q    <= pdir_nx;
      cnt_q     <= cnt_nx;
      up_n      <= ~(low_nx & dir_nx);
      dn_n      <= ~(low_nx & ~dir_nx);
      cnt_clk_n <= ~low_nx;
    end
  end
endmodule

// File: rtl/quad_clk_conv.sv
module quad_clk_conv
  import qcc_pkg::*;
#(
  parameter int FILT_LEN = 4,
  parameter int PW_W     = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            enc_a,
  input  logic            enc_b,
  input  logic            mode_x4,
  input  logic [PW_W-1:0] pw_cfg,
  output logic            up_n,
  output logic            dn_n,
  output logic            cnt_clk_n,
  output logic            dir,
  output logic            err
);
  logic [1:0] raw;
  ab_t        filt;
  logic       ev, ev_up;

  assign raw = {enc_a, enc_b};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    qcc_filter #(.FILT_LEN(FILT_LEN)) i_filt (
      .clk(clk), .rst(rst), .raw(raw[g]), .level(filt[g])
    );
  end

  qcc_decode i_dec (
    .clk(clk), .rst(rst), .ab(filt), .mode_x4(mode_x4),
    .ev(ev), .ev_up(ev_up), .err(err)
  );

  qcc_pulse #(.PW_W(PW_W)) i_pulse (
    .clk(clk), .rst(rst), .ev(ev), .ev_up(ev_up), .pw_cfg(pw_cfg),
    .up_n(up_n), .dn_n(dn_n), .cnt_clk_n(cnt_clk_n), .dir(dir)
  );
endmodule

// File: rtl/quad_clk_conv_chk.sv
module quad_clk_conv_chk (
  input logic clk,
  input logic rst,
  input logic up_n,
  input logic dn_n,
  input logic cnt_clk_n,
  input logic dir,
  input logic err
);
  a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (up_n && dn_n && cnt_clk_n && !err));

  a_r5_split_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(!up_n && !dn_n));

  a_r5_clk_covers_split: assert property (@(posedge clk) disable iff (rst)
    cnt_clk_n == (up_n && dn_n));

  a_r6_dir_stable: assert property (@(posedge clk) disable iff (rst)
    (!cnt_clk_n && !$past(cnt_clk_n)) |-> $stable(dir));

  a_r6_dir_matches: assert property (@(posedge clk) disable iff (rst)
    (!up_n |-> dir) and (!dn_n |-> !dir));

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
endmodule

bind quad_clk_conv quad_clk_conv_chk i_chk (
  .clk(clk), .rst(rst), .up_n(up_n), .dn_n(dn_n),
  .cnt_clk_n(cnt_clk_n), .dir(dir), .err(err)
);

// File: tb/test_quad_clk_conv.sv
`timescale 1ns/1ps
module test_quad_clk_conv;
  localparam int FILT_LEN = 4;
  localparam int PW_W     = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enc_a = 1'b0, enc_b = 1'b0, mode_x4 = 1'b1;
  logic [PW_W-1:0] pw_cfg = 8'd1;
  logic up_n, dn_n, cnt_clk_n, dir, err;

  always #4 clk = ~clk;   // 125 MHz

  quad_clk_conv #(.FILT_LEN(FILT_LEN), .PW_W(PW_W)) i_quad_clk_conv (
    .clk(clk), .rst(rst), .enc_a(enc_a), .enc_b(enc_b), .mode_x4(mode_x4),
    .pw_cfg(pw_cfg), .up_n(up_n), .dn_n(dn_n), .cnt_clk_n(cnt_clk_n),
    .dir(dir), .err(err)
  );

  int checks = 0, failures = 0;
  int n_up = 0, n_dn = 0, n_clk = 0;
  int exp_up = 0, exp_dn = 0;
  int width_bad = 0, dir_bad = 0, cur_w = 0, exp_w = 1;
  bit wchk = 1'b1;
  logic p_up = 1'b1, p_dn = 1'b1, p_clk = 1'b1, dir_at_fall = 1'b0;
  logic [1:0] st = 2'b00;

  function automatic logic [1:0] fwd(logic [1:0] s);
    case (s)
      2'b00: return 2'b10;
      2'b10: return 2'b11;
      2'b11: return 2'b01;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [1:0] rev(logic [1:0] s);
    case (s)
      2'b00: return 2'b01;
      2'b01: return 2'b11;
      2'b11: return 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  task automatic check(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Monitor: sample away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      if (p_up && !up_n) n_up++;
      if (p_dn && !dn_n) n_dn++;
      if (p_clk && !cnt_clk_n) begin
        n_clk++;
        dir_at_fall = dir;
        cur_w = 1;
      end else if (!p_clk && !cnt_clk_n) begin
        cur_w++;
        if (dir != dir_at_fall) dir_bad++;
      end
      if (!p_clk && cnt_clk_n && wchk && cur_w != exp_w) width_bad++;
      if (!up_n && !dir) dir_bad++;
      if (!dn_n && dir) dir_bad++;
    end
    p_up = up_n; p_dn = dn_n; p_clk = cnt_clk_n;
  end

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic step(bit up, int hold);
    logic [1:0] nx;
    nx = up ? fwd(st) : rev(st);
    if (mode_x4) begin
      if (up) exp_up++; else exp_dn++;
    end else if (nx == 2'b00) begin
      if (up) exp_up++; else exp_dn++;
    end
    st = nx;
    enc_a = st[1]; enc_b = st[0];
    wait_clk(hold);
  endtask

  task automatic seg_start(bit m, int pw);
    mode_x4 = m;
    pw_cfg = PW_W'(pw);
    exp_w = (pw == 0) ? 1 : pw;
    wait_clk(2);
    n_up = 0; n_dn = 0; n_clk = 0; exp_up = 0; exp_dn = 0;
    width_bad = 0; dir_bad = 0;
  endtask

  task automatic seg_end(string tag);
    wait_clk(FILT_LEN + 40);
    check({tag, " up count"}, n_up, exp_up);
    check({tag, " down count"}, n_dn, exp_dn);
    check({tag, " R5 clock count"}, n_clk, exp_up + exp_dn);
    check({tag, " R7 width"}, width_bad, 0);
    check({tag, " R6 dir"}, dir_bad, 0);
  endtask

  task automatic do_reset();
    rst = 1'b1; enc_a = 1'b0; enc_b = 1'b0; st = 2'b00;
    wait_clk(3);
    rst = 1'b0;
    wait_clk(2);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    int pw, hold;
    void'($urandom(32'd20240611));
    do_reset();
    // R1 reset state
    check("R1 up_n", up_n, 1);
    check("R1 dn_n", dn_n, 1);
    check("R1 cnt_clk_n", cnt_clk_n, 1);
    check("R1 dir", dir, 0);
    check("R1 err", err, 0);

    // R2 R4: directed forward then reverse cycle in x4
    seg_start(1'b1, 2);
    for (int i = 0; i < 4; i++) step(1'b1, 12);
    seg_end("R2 R4 fwd x4");
    seg_start(1'b1, 3);
    for (int i = 0; i < 4; i++) step(1'b0, 12);
    seg_end("R2 R4 rev x4");

    // R3: x1 forward and reverse cycles
    seg_start(1'b0, 2);
    for (int i = 0; i < 8; i++) step(1'b1, 12);
    seg_end("R3 fwd x1");
    seg_start(1'b0, 2);
    for (int i = 0; i < 8; i++) step(1'b0, 12);
    seg_end("R3 rev x1");

    // R7: width 0 acts as 1, and a wide pulse
    seg_start(1'b1, 0);
    for (int i = 0; i < 5; i++) step(1'b1, 10);
    seg_end("R7 pw0");
    seg_start(1'b1, 7);
    for (int i = 0; i < 5; i++) step(1'b0, 16);
    seg_end("R7 pw7");

    // Random walks, both modes
    for (int s = 0; s < 16; s++) begin
      pw = int'($urandom_range(0, 5));
      seg_start(1'(s % 2), pw);
      for (int i = 0; i < 24; i++) begin
        hold = FILT_LEN + pw + 4 + int'($urandom_range(0, 3));
        step(1'($urandom_range(0, 1)), hold);
      end
      seg_end("R2 R3 R4 random");
    end

    // R8: short glitch on A, then on B
    seg_start(1'b1, 2);
    enc_a = ~st[1]; wait_clk(FILT_LEN - 2); enc_a = st[1]; wait_clk(12);
    enc_b = ~st[0]; wait_clk(FILT_LEN - 1); enc_b = st[0]; wait_clk(12);
    seg_end("R8 glitch");

    // R10: pulses wider than edge spacing
    seg_start(1'b1, 12);
    wchk = 1'b0;
    for (int i = 0; i < 8; i++) step(1'b1, FILT_LEN + 2);
    seg_end("R10 restart");
    wchk = 1'b1;

    // R9: double change, sticky until reset
    do_reset();
    seg_start(1'b1, 2);
    check("R9 err before", err, 0);
    enc_a = 1'b1; enc_b = 1'b1; wait_clk(15);
    check("R9 err set", err, 1);
    enc_a = 1'b0; enc_b = 1'b0; wait_clk(15);
    st = 2'b00;
    for (int i = 0; i < 3; i++) step(1'b1, 12);
    check("R9 err held", err, 1);
    seg_end("R9 no pulse");
    do_reset();
    check("R9 R1 err cleared", err, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule